// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two W-bit unsigned operands one bit position per clock, using a single full adder and a single carry flip-flop. Both operands are written in parallel into two right-shifting registers. On every enabled cycle the least significant bits of both registers enter the full adder together with the stored carry. The sum bit is fed back into the top of the first operand register, and the carry-out is registered for the next position. After W enabled cycles the first register holds the W-bit sum and the carry flip-flop holds the carry out of the most significant position.

The second operand register takes a serial input at its top end. A producer can therefore stream the next operand into it while the current one shifts out. An internal step counter ends the addition on its own after the W-th shift and raises a one-cycle completion pulse. Further shift requests have no effect until a new load. A load always wins over a shift request in the same cycle.

Top module: `bitser_add`

## Requirements
- R1: While `clr` is high at a rising edge, the next state is `sum_out` = 0, `carry_out` = 0 and `done` = 0. `clr` is synchronous and active high.
- R2: A cycle with `load` high writes `a_in` to `sum_out` and clears `carry_out` and `done` at that edge.
- R3: After a load followed by exactly W enabled shift cycles, `sum_out` equals (A + B) mod 2^W and `carry_out` equals bit W of A + B.
- R4: `done` is high for exactly the one cycle after the edge that performs the W-th shift, and is low at all other times.
- R5: A cycle with `shift_en` low and `load` low leaves `sum_out` and `carry_out` unchanged. An addition paused this way and then resumed still gives the R3 result.
- R6: Once an addition has completed, `shift_en` has no effect on `sum_out`, `carry_out` or `done` until the next load.
- R7: When `load` and `shift_en` are both high, the load is performed and no shift happens. The W shifts that follow then give the R3 result.
- R8: The bits presented on `b_ser` during an addition have no effect on that addition's result.
- R9: After k enabled shifts (1 ≤ k ≤ W), `sum_out` holds the low k sum bits in its top k positions, with sum bit 0 at position W-k. The remaining low positions hold A shifted right by k.
- R10: A `clr` during an addition aborts it. Afterwards, `shift_en` alone changes nothing and `done` stays low until a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous active-high clear of all state |
| load | input | 1 | Parallel load of both operands; clears carry and restarts the step count |
| shift_en | input | 1 | Enables one bit step per clock while an addition is running |
| a_in | input | W | Operand A, parallel |
| b_in | input | W | Operand B, parallel |
| b_ser | input | 1 | Serial bit shifted into the top of the B register on each step |
| sum_out | output | W | Contents of the A register: the sum once the addition completes |
| carry_out | output | 1 | Carry flip-flop: carry out of the full sum once complete |
| done | output | 1 | One-cycle pulse after the final step |

## Verification
The bench covers operand pairs that carry through every bit position: all ones plus one, and all ones plus all ones. It also covers pairs that generate no carry at all. A design with a wrong carry capture or carry clearing would show a wrong top bit or a stale carry in the next addition. It checks the register contents after every step, which catches a shift in the wrong direction or a sum fed into the wrong end. It also checks the exact cycle of `done`, which catches a counter that is off by one. Pausing mid-addition, continuing to shift after completion, loading while a shift is requested, toggling the serial B input, and clearing mid-operation each target a design that keeps shifting when it should hold, or that lets the wrong control win.

// File: rtl/bitser_pkg.sv
package bitser_pkg;

    // One full-adder result: sum bit and carry out
    typedef struct packed {
        logic sum;
        logic cry;
    } fa_res_t;

    // Sequencer phase
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    function automatic fa_res_t full_add(input logic x, input logic y, input logic ci);
        fa_res_t r;
        r.sum = x ^ y ^ ci;
        r.cry = (x & y) | (x & ci) | (y & ci);
        return r;
    endfunction

endpackage

// File: rtl/bitser_opreg.sv
// Right-shifting operand register with parallel load and a serial input at the top.
module bitser_opreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         ld,
    input  logic         sh,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] q,
    output logic         lsb
);

    logic [W-1:0] shifted;

    generate
        if (W == 1) begin : g_one
            assign shifted = ser_in;
        end else begin : g_many
            assign shifted = {ser_in, q[W-1:1]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr) begin
            q <= '0;
        end else if (ld) begin
            q <= par_in;
        end else if (sh) begin
            q <= shifted;
        end
    end

    assign lsb = q[0];

endmodule

// File: rtl/bitser_seq.sv
// Step sequencer: counts W steps after a load, then stops and pulses done.
module bitser_seq
    import bitser_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic clr,
    input  logic load,
    input  logic shift_en,
    output logic step,
    output logic done
);

    localparam int CW = (W < 2) ? 1 : $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic          last;

    assign step = (phase == PH_RUN) && shift_en && !load;
    assign last = step && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (clr) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= last;
            if (load) begin
                phase <= PH_RUN;
                cnt   <= '0;
            end else if (step) begin
                if (last) begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bitser_add.sv
// Bit-serial adder: two shift registers, one full adder, one carry flip-flop.
module bitser_add
    import bitser_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         load,
    input  logic         shift_en,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         b_ser,
    output logic [W-1:0] sum_out,
    output logic         carry_out,
    output logic         done
);

    logic         step;
    logic         a_bit;
    logic         b_bit;
    logic         cry_q;
    fa_res_t      fa;
    logic [W-1:0] b_q;

    bitser_seq #(.W(W)) u_seq (
        .clk      (clk),
        .clr      (clr),
        .load     (load),
        .shift_en (shift_en),
        .step     (step),
        .done     (done)
    );

    assign fa = full_add(a_bit, b_bit, cry_q);

    // Operand A: sum bits re-enter at the top
    bitser_opreg #(.W(W)) u_areg (
        .clk    (clk),
        .clr    (clr),
        .ld     (load),
        .sh     (step),
        .par_in (a_in),
        .ser_in (fa.sum),
        .q      (sum_out),
        .lsb    (a_bit)
    );

    // Operand B: refilled from the external serial input
    bitser_opreg #(.W(W)) u_breg (
        .clk    (clk),
        .clr    (clr),
        .ld     (load),
        .sh     (step),
        .par_in (b_in),
        .ser_in (b_ser),
        .q      (b_q),
        .lsb    (b_bit)
    );

    always_ff @(posedge clk) begin
        if (clr || load) begin
            cry_q <= 1'b0;
        end else if (step) begin
            cry_q <= fa.cry;
        end
    end

    assign carry_out = cry_q;

endmodule

// File: rtl/bitser_add_chk.sv
module bitser_add_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         clr,
    input logic         load,
    input logic         shift_en,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         b_ser,
    input logic [W-1:0] sum_out,
    input logic         carry_out,
    input logic         done
);

    // R1
    clear_state_chk: assert property (@(posedge clk)
        clr |=> (sum_out == '0) && !carry_out && !done);

    // R2
    load_write_chk: assert property (@(posedge clk) disable iff (clr)
        load |=> (sum_out == $past(a_in)) && !carry_out && !done);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (clr)
        done |=> !done);

    // R5
    pause_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (!shift_en && !load) |=> $stable(sum_out) && $stable(carry_out));

    // R6
    after_done_chk: assert property (@(posedge clk) disable iff (clr)
        (done && !load) |=> $stable(sum_out) && $stable(carry_out) && !done);

endmodule

bind bitser_add bitser_add_chk #(.W(W)) u_chk (.*);

// File: tb/test_bitser_add.sv
module test_bitser_add;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr;
    logic         load;
    logic         shift_en;
    logic [W-1:0] a_in;
    logic [W-1:0] b_in;
    logic         b_ser;
    logic [W-1:0] sum_out;
    logic         carry_out;
    logic         done;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bitser_add #(.W(W)) i_bitser_add (
        .clk       (clk),
        .clr       (clr),
        .load      (load),
        .shift_en  (shift_en),
        .a_in      (a_in),
        .b_in      (b_in),
        .b_ser     (b_ser),
        .sum_out   (sum_out),
        .carry_out (carry_out),
        .done      (done)
    );

    // {A, B} pairs
    localparam logic [15:0] VEC [8] = '{
        16'h00_00, 16'hFF_01, 16'hFF_FF, 16'h5A_A5,
        16'h80_80, 16'h37_C9, 16'h01_00, 16'h7F_01
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b, input logic se);
        a_in = a; b_in = b; load = 1'b1; shift_en = se;
        tick();
        load = 1'b0;
        chk(sum_out == a, "R2 sum after load", sum_out, a);
        chk(carry_out == 1'b0 && done == 1'b0, "R2 carry/done after load",
            {carry_out, done}, 0);
    endtask

    // k-th shift (1-based) with partial and final checks
    task automatic do_shift(input logic [W-1:0] a, input logic [W-1:0] b, input int k,
                            input logic ser, input string rtag);
        logic [W:0]   full;
        logic [W-1:0] part;
        full = {1'b0, a} + {1'b0, b};
        shift_en = 1'b1; b_ser = ser;
        tick();
        part = W'((int'(full[W-1:0]) << (W - k)) | (int'(a) >> k));
        chk(sum_out == part, "R9 partial sum", sum_out, part);
        if (k < W) begin
            chk(done == 1'b0, "R4 done early", done, 0);
        end else begin
            chk(done == 1'b1, "R4 done at last step", done, 1);
            chk(sum_out == full[W-1:0], rtag, sum_out, full[W-1:0]);
            chk(carry_out == full[W], "R3 carry out", carry_out, full[W]);
        end
    endtask

    task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [W-1:0] ser, input string rtag);
        do_load(a, b, 1'b0);
        for (int k = 1; k <= W; k++) do_shift(a, b, k, ser[k-1], rtag);
        shift_en = 1'b0;
        tick();
        chk(done == 1'b0, "R4 done one cycle only", done, 0);
    endtask

    initial begin
        #(200000 * 10);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] hold_s;
        logic         hold_c;
        clr = 1'b1; load = 1'b0; shift_en = 1'b0; a_in = '0; b_in = '0; b_ser = 1'b0;
        tick(); tick();
        // R1
        chk(sum_out == '0 && !carry_out && !done, "R1 reset state",
            {carry_out, done, sum_out}, 0);
        clr = 1'b0;
        tick();

        // R3 table walk
        for (int i = 0; i < 8; i++) run_add(VEC[i][15:8], VEC[i][7:0], 8'h00, "R3 sum");

        // R8 serial B input must not matter
        run_add(8'hB6, 8'h6D, 8'hFF, "R8 sum with b_ser ones");
        run_add(8'hB6, 8'h6D, 8'hA5, "R8 sum with b_ser pattern");

        // R5 pause mid-operation
        do_load(8'hE7, 8'h3C, 1'b0);
        for (int k = 1; k <= 3; k++) do_shift(8'hE7, 8'h3C, k, 1'b0, "R5 sum");
        shift_en = 1'b0;
        hold_s = sum_out; hold_c = carry_out;
        for (int j = 0; j < 4; j++) begin
            tick();
            chk(sum_out == hold_s && carry_out == hold_c && !done, "R5 hold while paused",
                {carry_out, sum_out}, {hold_c, hold_s});
        end
        for (int k = 4; k <= W; k++) do_shift(8'hE7, 8'h3C, k, 1'b1, "R5 sum after resume");

        // R6 shifts after completion
        hold_s = sum_out; hold_c = carry_out;
        for (int j = 0; j < 3; j++) begin
            shift_en = 1'b1;
            tick();
            chk(sum_out == hold_s && carry_out == hold_c && !done, "R6 no effect after done",
                {done, carry_out, sum_out}, {1'b0, hold_c, hold_s});
        end
        shift_en = 1'b0;

        // R7 load wins over shift
        do_load(8'hC3, 8'h4E, 1'b1);
        for (int k = 1; k <= W; k++) do_shift(8'hC3, 8'h4E, k, 1'b0, "R7 sum after load+shift");
        shift_en = 1'b0;
        tick();

        // R10 clear mid-operation
        do_load(8'h9F, 8'h71, 1'b0);
        for (int k = 1; k <= 3; k++) do_shift(8'h9F, 8'h71, k, 1'b0, "R10 pre-clear");
        clr = 1'b1;
        tick();
        chk(sum_out == '0 && !carry_out && !done, "R10 clear aborts",
            {carry_out, done, sum_out}, 0);
        clr = 1'b0; shift_en = 1'b1;
        for (int j = 0; j < W + 2; j++) begin
            tick();
            chk(sum_out == '0 && !carry_out && !done, "R10 idle after clear",
                {carry_out, done, sum_out}, 0);
        end
        shift_en = 1'b0;
        tick();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule